// File: doc/BRIEF.md
# Posted Write Buffer with Imprecise Fault Reporting

This block sits between the execute stage of a processor pipeline and the memory write port. The execute stage hands over a store (address, data, byte enables) and continues at once. The buffer then writes its entries to memory by itself, in the order the stores were issued, with only one memory transaction open at a time. When it holds as many stores as it has room for, it refuses further stores until a slot frees up.

A memory write can come back with an error after later instructions have already executed. The buffer therefore reports the fault with the program counter that is current in the cycle the error response arrives, not with the counter of the store that caused it. It also reports the failing address. After an error, every write still held in the buffer is dropped.

A synchronizing no-op acts as a barrier. While a barrier is waiting, the buffer asserts a stall until every earlier write has finished. A fault from any of those writes has therefore been reported by the time the barrier is released. A store offered in the same cycle as a barrier counts as older than the barrier.

Top module: `wr_post_buf`

## Requirements
- R1: After synchronous reset, st_ready is 1, mem_req is 0, buf_empty is 1, fault_valid is 0 and sync_stall is 0.
- R2: The buffer holds up to DEPTH (default 2) stores. st_ready is 1 exactly when fewer than DEPTH stores are held. A store is taken in a cycle where st_valid and st_ready are both 1, without waiting for memory.
- R3: mem_req is 1 exactly when the buffer holds a store. mem_addr, mem_data and mem_be then show the oldest held store, and they stay unchanged until a cycle with mem_ack is 1.
- R4: In a cycle with mem_req, mem_ack and not mem_err, the oldest store is removed. From the next cycle the following store, in issue order, is presented.
- R5: In a cycle with mem_req, mem_ack and mem_err all 1, fault_valid is 1 in the next cycle for exactly one cycle. fault_pc is then the cur_pc value of the error cycle, and fault_addr is the address of the failing write.
- R6: A write error discards every held store, including a store accepted in the error cycle. In the next cycle buf_empty is 1 and mem_req is 0.
- R7: sync_stall is 1 exactly when sync_req is 1 and either the buffer holds a store or st_valid is 1. The barrier completes in a cycle where sync_req is 1 and sync_stall is 0.
- R8: When a store and a barrier arrive in the same cycle, the store is taken first and the barrier stalls until that store has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store offered by execute stage |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| mem_req | output | 1 | Write request to memory |
| mem_addr | output | ADDR_W | Write address |
| mem_data | output | DATA_W | Write data |
| mem_be | output | DATA_W/8 | Write byte enables |
| mem_ack | input | 1 | Memory response for the current write |
| mem_err | input | 1 | Response is an error (valid with mem_ack) |
| cur_pc | input | PC_W | Program counter of the instruction now current |
| fault_valid | output | 1 | One-cycle write fault report |
| fault_pc | output | PC_W | PC current when the fault arrived |
| fault_addr | output | ADDR_W | Address of the failing write |
| sync_req | input | 1 | Barrier no-op waiting to complete |
| sync_stall | output | 1 | Barrier must hold |
| buf_empty | output | 1 | No store is held |

## Verification
The hardest situation to reach from the ports is an error response that arrives while the buffer is full, a new store is offered in the same cycle and a barrier is waiting. In that cycle the flush, the refused or discarded push and the barrier stall all interact. The stimulus reaches it with phases that first hold back acknowledgements so the buffer fills, and then give responses with a high error rate while stores and barriers are offered densely. A reference queue in the bench predicts every output each cycle.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int PC_W   = 32;
    localparam int BE_W  = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } wb_entry_t;

    function automatic int ptr_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  wb_entry_t push_ent,
    input  logic      pop,
    input  logic      flush,
    output wb_entry_t head,
    output logic      empty,
    output logic      full
);
    localparam int PW = ptr_bits(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    wb_entry_t      slot [DEPTH];
    logic [PW-1:0]  rd_ptr;
    logic [PW-1:0]  wr_ptr;
    logic [CW-1:0]  cnt;
    logic           do_push;
    logic           do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign do_push = push && !flush;
    assign do_pop  = pop && !flush;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (do_push && wr_ptr == PW'(g)) begin
                    slot[g] <= push_ent;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    assign head  = slot[rd_ptr];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/wbuf_port.sv
module wbuf_port
    import wbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              empty,
    input  wb_entry_t         head,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [PC_W-1:0]   cur_pc,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BE_W-1:0]   mem_be,
    output logic              pop,
    output logic              flush,
    output logic              fault_valid,
    output logic [PC_W-1:0]   fault_pc,
    output logic [ADDR_W-1:0] fault_addr
);
    logic done;

    assign mem_req  = !empty;
    assign mem_addr = head.addr;
    assign mem_data = head.data;
    assign mem_be   = head.be;

    assign done  = mem_req && mem_ack;
    assign pop   = done && !mem_err;
    assign flush = done && mem_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_valid <= 1'b0;
            fault_pc    <= '0;
            fault_addr  <= '0;
        end else begin
            fault_valid <= flush;
            if (flush) begin
                fault_pc   <= cur_pc;
                fault_addr <= head.addr;
            end
        end
    end
endmodule

// File: rtl/wbuf_sync.sv
module wbuf_sync (
    input  logic sync_req,
    input  logic empty,
    input  logic st_valid,
    output logic sync_stall
);
    // a store in the same cycle is older than the barrier
    assign sync_stall = sync_req && (!empty || st_valid);
endmodule

// File: rtl/wr_post_buf.sv
module wr_post_buf
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BE_W-1:0]   mem_be,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [PC_W-1:0]   cur_pc,
    output logic              fault_valid,
    output logic [PC_W-1:0]   fault_pc,
    output logic [ADDR_W-1:0] fault_addr,
    input  logic              sync_req,
    output logic              sync_stall,
    output logic              buf_empty
);
    wb_entry_t in_ent;
    wb_entry_t head;
    logic      empty;
    logic      full;
    logic      pop;
    logic      flush;

    assign in_ent = '{addr: st_addr, data: st_data, be: st_be};
    assign st_ready  = !full;
    assign buf_empty = empty;

    wbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (st_valid && !full),
        .push_ent (in_ent),
        .pop      (pop),
        .flush    (flush),
        .head     (head),
        .empty    (empty),
        .full     (full)
    );

    wbuf_port u_port (
        .clk         (clk),
        .rst         (rst),
        .empty       (empty),
        .head        (head),
        .mem_ack     (mem_ack),
        .mem_err     (mem_err),
        .cur_pc      (cur_pc),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_data    (mem_data),
        .mem_be      (mem_be),
        .pop         (pop),
        .flush       (flush),
        .fault_valid (fault_valid),
        .fault_pc    (fault_pc),
        .fault_addr  (fault_addr)
    );

    wbuf_sync u_sync (
        .sync_req   (sync_req),
        .empty      (empty),
        .st_valid   (st_valid),
        .sync_stall (sync_stall)
    );
endmodule

// File: rtl/wr_post_buf_chk.sv
module wr_post_buf_chk
    import wbuf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              st_valid,
    input logic              st_ready,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              mem_err,
    input logic [PC_W-1:0]   cur_pc,
    input logic              fault_valid,
    input logic [PC_W-1:0]   fault_pc,
    input logic              sync_req,
    input logic              sync_stall,
    input logic              buf_empty
);
    p_ready_when_empty_r2: assert property (@(posedge clk) disable iff (rst)
        buf_empty |-> st_ready);

    p_refuse_only_loaded_r2: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready) |-> (!buf_empty && mem_req));

    p_hold_request_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_fault_pc_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_err) |=> (fault_valid && fault_pc == $past(cur_pc)));

    p_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_err) |=> (buf_empty && !mem_req));

    p_barrier_drained_r7: assert property (@(posedge clk) disable iff (rst)
        (sync_req && !sync_stall) |-> (!mem_req && !st_valid));
endmodule

bind wr_post_buf wr_post_buf_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .st_valid    (st_valid),
    .st_ready    (st_ready),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .cur_pc      (cur_pc),
    .fault_valid (fault_valid),
    .fault_pc    (fault_pc),
    .sync_req    (sync_req),
    .sync_stall  (sync_stall),
    .buf_empty   (buf_empty)
);

// File: tb/sim_wr_post_buf.sv
`timescale 1ns/1ps
module sim_wr_post_buf;
    import wbuf_pkg::*;

    localparam int DEPTH = 2;

    logic              clk = 1'b0;
    logic              rst;
    logic              st_valid;
    logic              st_ready;
    logic [ADDR_W-1:0] st_addr;
    logic [DATA_W-1:0] st_data;
    logic [BE_W-1:0]   st_be;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_data;
    logic [BE_W-1:0]   mem_be;
    logic              mem_ack;
    logic              mem_err;
    logic [PC_W-1:0]   cur_pc;
    logic              fault_valid;
    logic [PC_W-1:0]   fault_pc;
    logic [ADDR_W-1:0] fault_addr;
    logic              sync_req;
    logic              sync_stall;
    logic              buf_empty;

    always #2 clk = ~clk;

    wr_post_buf #(.DEPTH(DEPTH)) u0 (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model
    logic [ADDR_W-1:0] q_addr [DEPTH];
    logic [DATA_W-1:0] q_data [DEPTH];
    logic [BE_W-1:0]   q_be   [DEPTH];
    int                m_cnt;
    bit                m_fv;
    logic [PC_W-1:0]   m_fpc;
    logic [ADDR_W-1:0] m_faddr;
    bit                prev_pop;
    bit                prev_err;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_stall(input bit sreq, input bit sv, input int cnt);
        return sreq && (cnt != 0 || sv);
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_fv = 0; m_fpc = '0; m_faddr = '0;
        prev_pop = 0; prev_err = 0;
    endtask

    task automatic cycle(input int p_st, input int p_ack, input int p_err, input int p_sync);
        bit ready_b;
        bit err_ev;
        string tq;
        @(negedge clk);
        st_valid = ($urandom % 100) < p_st;
        st_addr  = $urandom & 32'hFFFF_FFFC;
        st_data  = $urandom;
        st_be    = BE_W'($urandom % 15 + 1);
        sync_req = ($urandom % 100) < p_sync;
        mem_ack  = ($urandom % 100) < p_ack;
        mem_err  = mem_ack && (($urandom % 100) < p_err);
        cur_pc   = $urandom & 32'hFFFF_FFFE;
        #1;
        tq = prev_err ? "R6" : "R3";
        chk(buf_empty == (m_cnt == 0), tq, "buf_empty", 64'(buf_empty), 64'(m_cnt == 0));
        chk(mem_req == (m_cnt != 0), tq, "mem_req", 64'(mem_req), 64'(m_cnt != 0));
        chk(st_ready == (m_cnt < DEPTH), "R2", "st_ready", 64'(st_ready), 64'(m_cnt < DEPTH));
        if (m_cnt != 0) begin
            tq = prev_pop ? "R4" : "R3";
            chk(mem_addr == q_addr[0], tq, "mem_addr", 64'(mem_addr), 64'(q_addr[0]));
            chk(mem_data == q_data[0], tq, "mem_data", 64'(mem_data), 64'(q_data[0]));
            chk(mem_be == q_be[0], tq, "mem_be", 64'(mem_be), 64'(q_be[0]));
        end
        tq = (st_valid && sync_req) ? "R8" : "R7";
        chk(sync_stall == exp_stall(sync_req, st_valid, m_cnt), tq, "sync_stall",
            64'(sync_stall), 64'(exp_stall(sync_req, st_valid, m_cnt)));
        chk(fault_valid == m_fv, "R5", "fault_valid", 64'(fault_valid), 64'(m_fv));
        if (m_fv) begin
            chk(fault_pc == m_fpc, "R5", "fault_pc", 64'(fault_pc), 64'(m_fpc));
            chk(fault_addr == m_faddr, "R5", "fault_addr", 64'(fault_addr), 64'(m_faddr));
        end
        @(posedge clk);
        ready_b = (m_cnt < DEPTH);
        err_ev = 0; prev_pop = 0; m_fv = 0;
        if (m_cnt != 0 && mem_ack) begin
            if (mem_err) begin
                err_ev = 1; m_fv = 1; m_fpc = cur_pc; m_faddr = q_addr[0]; m_cnt = 0;
            end else begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    q_addr[i] = q_addr[i+1]; q_data[i] = q_data[i+1]; q_be[i] = q_be[i+1];
                end
                m_cnt--; prev_pop = 1;
            end
        end
        if (!err_ev && st_valid && ready_b) begin
            q_addr[m_cnt] = st_addr; q_data[m_cnt] = st_data; q_be[m_cnt] = st_be;
            m_cnt++;
        end
        prev_err = err_ev;
    endtask

    initial begin
        for (int w = 0; w < 150000; w++) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1; st_valid = 0; st_addr = '0; st_data = '0; st_be = '0;
        mem_ack = 0; mem_err = 0; cur_pc = '0; sync_req = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(st_ready == 1'b1, "R1", "reset st_ready", 64'(st_ready), 64'd1);
        chk(mem_req == 1'b0, "R1", "reset mem_req", 64'(mem_req), 64'd0);
        chk(buf_empty == 1'b1, "R1", "reset buf_empty", 64'(buf_empty), 64'd1);
        chk(fault_valid == 1'b0, "R1", "reset fault_valid", 64'(fault_valid), 64'd0);
        chk(sync_stall == 1'b0, "R1", "reset sync_stall", 64'(sync_stall), 64'd0);
        rst = 0;
        // fill with no acknowledge, stores and barriers together
        repeat (6)   cycle(100, 0, 0, 100);
        // drain cleanly
        repeat (10)  cycle(0, 100, 0, 60);
        // full buffer then error with store and barrier in the same cycle
        repeat (4)   cycle(100, 0, 0, 100);
        repeat (4)   cycle(100, 100, 100, 100);
        // mixed random phases
        repeat (3000) cycle(60, 50, 10, 30);
        repeat (2000) cycle(90, 20, 40, 70);
        repeat (2000) cycle(30, 80, 5, 50);
        repeat (20)  cycle(0, 100, 0, 100);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule